// File: doc/BRIEF.md
# Scatter-Gather Copy Engine

This engine copies data between memory regions by walking a table of transfer elements held contiguously in memory. Each element takes three 32-bit words: a source address, a destination address and a control word holding a byte count and a final-element flag. Software writes the table's base address, then sets a start bit. The engine fetches each element, checks its byte count, and copies the payload one 32-bit word at a time: one read from the source and then one write to the destination.

A single memory master port with a valid/ready request channel and a response channel carries both the element fetches and the payload traffic. Only one request is outstanding at a time. Words on the bus are little-endian: bus bit 0 is bit 0 of the byte at the lowest address. A five-bit status word records a successful finish or the reason a run was aborted. The interrupt output stays high while any status bit is set, and software clears status bits by writing ones to them.

Top module: `sgdma_engine`

## Requirements
- R1: After reset the status register reads 0, `irq` is low and no memory request is issued until a run is started.
- R2: Writing a word with bit 0 set to the control register (offset 0x0) starts a run at the table address held at offset 0x8, which reads back as written. Element i occupies three words starting at base + 12*i, fetched in this order: source address, destination address, control word.
- R3: In the control word, bits [17:0] are the byte count and bit 31 is the final-element flag. Bits [30:18] are ignored.
- R4: For each element the engine moves count/4 words. Each word is read at the current source address and then written, with the same data, to the current destination address. Both addresses advance by 4 after each word.
- R5: Elements are handled strictly in table order. When the element flagged as final has moved its last word, the run stops and status bits 0 and 1 are set (status reads 0x03).
- R6: A byte count of zero, or one that is not a multiple of 256, sets status bit 4 (0x10) and ends the run without moving any word of that element.
- R7: An error response to any read, whether an element fetch or a source read, sets status bit 2 (0x04). The run ends at once and issues no further requests.
- R8: An error response to a destination write sets status bit 3 (0x08) and ends the run at once.
- R9: If MAX_ELEMS elements have completed without a final flag, the engine sets status bit 4 (0x10) and stops without fetching another element.
- R10: A start request written while a run is active has no effect on that run and does not begin another one.
- R11: The status register at offset 0x4 is write-1-to-clear: ones clear the matching bits and zeros leave bits unchanged. `irq` is high exactly while any status bit is set.
- R12: The memory port holds at most one request outstanding. A request keeps its address and direction while it is waiting for ready, and write data always equals the data of the read that came before it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | REG_AW | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, registered from `reg_addr` |
| m_req_valid | output | 1 | Memory request valid |
| m_req_ready | input | 1 | Memory request accepted |
| m_req_write | output | 1 | 1 = write, 0 = read |
| m_req_addr | output | ADDR_W | Memory byte address |
| m_req_wdata | output | 32 | Write data |
| m_rsp_valid | input | 1 | Response for the outstanding request |
| m_rsp_rdata | input | 32 | Read response data |
| m_rsp_err | input | 1 | Response carries an error |
| irq | output | 1 | High while any status bit is set |

## Verification
The copy path is tried on four kinds of table. A one-element table separates a correct word count and address stride from an off-by-one in the last word. A three-element table with different counts and reserved control bits set shows that elements run in order, that the next element is taken from the next 12-byte slot, and that the reserved bits are not read as part of the count. Tables with a bad count in a later element, or with no final flag at all, separate work completed before the abort from work that must never start. Error responses injected on an element fetch, on a mid-element source read and on a destination write show that the engine stops exactly at the failing word and records the correct cause bit. A restart written in the middle of a run must leave the write stream unchanged.

// File: rtl/sgdma_pkg.sv
package sgdma_pkg;

  localparam int WORD_W   = 32;
  localparam int LAST_BIT = 31;
  localparam int STAT_W   = 5;

  localparam int ST_RD_DONE = 0;
  localparam int ST_WR_DONE = 1;
  localparam int ST_RD_ERR  = 2;
  localparam int ST_WR_ERR  = 3;
  localparam int ST_SG_ERR  = 4;

  typedef enum logic [2:0] {
    W_IDLE,
    W_DREQ,
    W_DWAIT,
    W_CHECK,
    W_RREQ,
    W_RWAIT,
    W_WREQ,
    W_WWAIT
  } walk_state_e;

  typedef struct packed {
    logic done_ok;
    logic rd_err;
    logic wr_err;
    logic sg_err;
  } walk_evt_t;

endpackage

// File: rtl/sgdma_regs.sv
module sgdma_regs
  import sgdma_pkg::*;
#(
  parameter int REG_AW = 4,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [WORD_W-1:0] reg_wdata,
  output logic [WORD_W-1:0] reg_rdata,
  input  walk_evt_t         evt,
  output logic              start_req,
  output logic [ADDR_W-1:0] base_addr,
  output logic              irq
);

  localparam logic [REG_AW-1:0] OFS_CTRL = REG_AW'(0);
  localparam logic [REG_AW-1:0] OFS_STAT = REG_AW'(4);
  localparam logic [REG_AW-1:0] OFS_BASE = REG_AW'(8);

  logic [STAT_W-1:0] status;
  logic [STAT_W-1:0] status_nxt;
  logic [STAT_W-1:0] set_vec;
  logic [STAT_W-1:0] clr_vec;

  assign start_req = reg_we && (reg_addr == OFS_CTRL) && reg_wdata[0];

  always_comb begin
    set_vec = '0;
    set_vec[ST_RD_DONE] = evt.done_ok;
    set_vec[ST_WR_DONE] = evt.done_ok;
    set_vec[ST_RD_ERR]  = evt.rd_err;
    set_vec[ST_WR_ERR]  = evt.wr_err;
    set_vec[ST_SG_ERR]  = evt.sg_err;
    clr_vec = (reg_we && (reg_addr == OFS_STAT)) ? reg_wdata[STAT_W-1:0] : '0;
  end

  // one write-1-to-clear flop per status bit; a new event wins over a clear
  for (genvar b = 0; b < STAT_W; b++) begin : g_stat
    assign status_nxt[b] = set_vec[b] | (status[b] & ~clr_vec[b]);
    always_ff @(posedge clk) begin
      if (rst) status[b] <= 1'b0;
      else     status[b] <= status_nxt[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq       <= 1'b0;
      base_addr <= '0;
      reg_rdata <= '0;
    end else begin
      irq <= |status_nxt;
      if (reg_we && (reg_addr == OFS_BASE)) base_addr <= reg_wdata[ADDR_W-1:0];
      case (reg_addr)
        OFS_STAT: reg_rdata <= WORD_W'(status);
        OFS_BASE: reg_rdata <= WORD_W'(base_addr);
        default:  reg_rdata <= '0;
      endcase
    end
  end

endmodule

// File: rtl/sgdma_desc_check.sv
module sgdma_desc_check #(
  parameter int CNT_W    = 18,
  parameter int BLK_LOG2 = 8
) (
  input  logic [CNT_W-1:0] byte_cnt,
  output logic             cnt_ok,
  output logic [CNT_W-3:0] n_words
);

  // a count is legal when it is non-zero and a whole number of blocks
  assign cnt_ok  = (byte_cnt != '0) && (byte_cnt[BLK_LOG2-1:0] == '0);
  assign n_words = byte_cnt[CNT_W-1:2];

endmodule

// File: rtl/sgdma_walker.sv
module sgdma_walker
  import sgdma_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 18,
  parameter int BLK_LOG2  = 8,
  parameter int MAX_ELEMS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_req,
  input  logic [ADDR_W-1:0] base_addr,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic              m_req_write,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [WORD_W-1:0] m_req_wdata,
  input  logic              m_rsp_valid,
  input  logic [WORD_W-1:0] m_rsp_rdata,
  input  logic              m_rsp_err,
  output walk_evt_t         evt,
  output logic              busy
);

  localparam int EW = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1;
  localparam logic [EW-1:0]     ELEM_LAST = EW'(MAX_ELEMS - 1);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(4);

  walk_state_e       state;
  logic [ADDR_W-1:0] desc_ptr;
  logic [1:0]        word_k;
  logic [ADDR_W-1:0] src;
  logic [ADDR_W-1:0] dst;
  logic              c_last;
  logic [CNT_W-1:0]  c_cnt;
  logic [CNT_W-3:0]  words_left;
  logic [EW-1:0]     elem_cnt;
  logic [WORD_W-1:0] data_buf;

  logic              cnt_ok;
  logic [CNT_W-3:0]  n_words;
  logic              elem_end;

  sgdma_desc_check #(
    .CNT_W   (CNT_W),
    .BLK_LOG2(BLK_LOG2)
  ) u_check (
    .byte_cnt(c_cnt),
    .cnt_ok  (cnt_ok),
    .n_words (n_words)
  );

  assign busy        = (state != W_IDLE);
  assign m_req_valid = (state == W_DREQ) || (state == W_RREQ) || (state == W_WREQ);
  assign m_req_write = (state == W_WREQ);
  assign m_req_wdata = data_buf;

  always_comb begin
    case (state)
      W_RREQ:  m_req_addr = src;
      W_WREQ:  m_req_addr = dst;
      default: m_req_addr = desc_ptr;
    endcase
  end

  assign elem_end = (state == W_WWAIT) && m_rsp_valid && !m_rsp_err &&
                    (words_left == CNT_W'(1));

  always_comb begin
    evt.done_ok = elem_end && c_last;
    evt.rd_err  = m_rsp_valid && m_rsp_err &&
                  ((state == W_DWAIT) || (state == W_RWAIT));
    evt.wr_err  = m_rsp_valid && m_rsp_err && (state == W_WWAIT);
    evt.sg_err  = ((state == W_CHECK) && !cnt_ok) ||
                  (elem_end && !c_last && (elem_cnt == ELEM_LAST));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= W_IDLE;
      desc_ptr   <= '0;
      word_k     <= '0;
      src        <= '0;
      dst        <= '0;
      c_last     <= 1'b0;
      c_cnt      <= '0;
      words_left <= '0;
      elem_cnt   <= '0;
      data_buf   <= '0;
    end else begin
      case (state)
        W_IDLE: begin
          if (start_req) begin
            desc_ptr <= base_addr;
            word_k   <= '0;
            elem_cnt <= '0;
            state    <= W_DREQ;
          end
        end
        W_DREQ: if (m_req_ready) state <= W_DWAIT;
        W_DWAIT: begin
          if (m_rsp_valid) begin
            if (m_rsp_err) begin
              state <= W_IDLE;
            end else begin
              desc_ptr <= desc_ptr + STEP;
              case (word_k)
                2'd0:    src <= m_rsp_rdata[ADDR_W-1:0];
                2'd1:    dst <= m_rsp_rdata[ADDR_W-1:0];
                default: begin
                  c_last <= m_rsp_rdata[LAST_BIT];
                  c_cnt  <= m_rsp_rdata[CNT_W-1:0];
                end
              endcase
              if (word_k == 2'd2) begin
                state <= W_CHECK;
              end else begin
                word_k <= word_k + 2'd1;
                state  <= W_DREQ;
              end
            end
          end
        end
        W_CHECK: begin
          if (!cnt_ok) begin
            state <= W_IDLE;
          end else begin
            words_left <= n_words;
            state      <= W_RREQ;
          end
        end
        W_RREQ: if (m_req_ready) state <= W_RWAIT;
        W_RWAIT: begin
          if (m_rsp_valid) begin
            if (m_rsp_err) begin
              state <= W_IDLE;
            end else begin
              data_buf <= m_rsp_rdata;
              state    <= W_WREQ;
            end
          end
        end
        W_WREQ: if (m_req_ready) state <= W_WWAIT;
        W_WWAIT: begin
          if (m_rsp_valid) begin
            if (m_rsp_err) begin
              state <= W_IDLE;
            end else begin
              src <= src + STEP;
              dst <= dst + STEP;
              if (words_left == CNT_W'(1)) begin
                if (c_last || (elem_cnt == ELEM_LAST)) begin
                  state <= W_IDLE;
                end else begin
                  elem_cnt <= elem_cnt + EW'(1);
                  word_k   <= '0;
                  state    <= W_DREQ;
                end
              end else begin
                words_left <= words_left - CNT_W'(1);
                state      <= W_RREQ;
              end
            end
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgdma_engine.sv
module sgdma_engine
  import sgdma_pkg::*;
#(
  parameter int REG_AW    = 4,
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 18,
  parameter int BLK_LOG2  = 8,
  parameter int MAX_ELEMS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              m_req_valid,
  input  logic              m_req_ready,
  output logic              m_req_write,
  output logic [ADDR_W-1:0] m_req_addr,
  output logic [31:0]       m_req_wdata,
  input  logic              m_rsp_valid,
  input  logic [31:0]       m_rsp_rdata,
  input  logic              m_rsp_err,
  output logic              irq
);

  walk_evt_t         evt;
  logic              start_req;
  logic [ADDR_W-1:0] base_addr;
  logic              run_busy;

  sgdma_regs #(
    .REG_AW(REG_AW),
    .ADDR_W(ADDR_W)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .evt      (evt),
    .start_req(start_req),
    .base_addr(base_addr),
    .irq      (irq)
  );

  sgdma_walker #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .BLK_LOG2 (BLK_LOG2),
    .MAX_ELEMS(MAX_ELEMS)
  ) u_walker (
    .clk        (clk),
    .rst        (rst),
    .start_req  (start_req),
    .base_addr  (base_addr),
    .m_req_valid(m_req_valid),
    .m_req_ready(m_req_ready),
    .m_req_write(m_req_write),
    .m_req_addr (m_req_addr),
    .m_req_wdata(m_req_wdata),
    .m_rsp_valid(m_rsp_valid),
    .m_rsp_rdata(m_rsp_rdata),
    .m_rsp_err  (m_rsp_err),
    .evt        (evt),
    .busy       (run_busy)
  );

endmodule

// File: rtl/sgdma_engine_chk.sv
module sgdma_engine_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              m_req_valid,
  input logic              m_req_ready,
  input logic              m_req_write,
  input logic [ADDR_W-1:0] m_req_addr,
  input logic [31:0]       m_req_wdata,
  input logic              m_rsp_valid,
  input logic [31:0]       m_rsp_rdata,
  input logic              m_rsp_err,
  input logic              irq,
  input logic              run_busy
);

  logic        pend;
  logic        pend_wr;
  logic        have_rd;
  logic [31:0] last_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend    <= 1'b0;
      pend_wr <= 1'b0;
      have_rd <= 1'b0;
      last_rd <= '0;
    end else begin
      if (m_req_valid && m_req_ready) begin
        pend    <= 1'b1;
        pend_wr <= m_req_write;
      end else if (m_rsp_valid) begin
        pend <= 1'b0;
      end
      if (pend && m_rsp_valid && !pend_wr && !m_rsp_err) begin
        have_rd <= 1'b1;
        last_rd <= m_rsp_rdata;
      end
    end
  end

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (rst)
    pend |-> !m_req_valid); // R12

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    m_req_valid && !m_req_ready |=> m_req_valid && $stable(m_req_addr) && $stable(m_req_write)); // R12

  AST_WDATA_FROM_READ: assert property (@(posedge clk) disable iff (rst)
    m_req_valid && m_req_write |-> have_rd && (m_req_wdata == last_rd)); // R4

  AST_ERR_ABORTS: assert property (@(posedge clk) disable iff (rst)
    m_rsp_valid && m_rsp_err && run_busy |=> !run_busy && irq); // R7

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !run_busy |-> !m_req_valid); // R1

endmodule

bind sgdma_engine sgdma_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .m_req_valid(m_req_valid),
  .m_req_ready(m_req_ready),
  .m_req_write(m_req_write),
  .m_req_addr (m_req_addr),
  .m_req_wdata(m_req_wdata),
  .m_rsp_valid(m_rsp_valid),
  .m_rsp_rdata(m_rsp_rdata),
  .m_rsp_err  (m_rsp_err),
  .irq        (irq),
  .run_busy   (run_busy)
);

// File: tb/test_sgdma_engine.sv
module test_sgdma_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        m_req_valid;
  logic        m_req_ready = 1'b0;
  logic        m_req_write;
  logic [31:0] m_req_addr;
  logic [31:0] m_req_wdata;
  logic        m_rsp_valid = 1'b0;
  logic [31:0] m_rsp_rdata = '0;
  logic        m_rsp_err = 1'b0;
  logic        irq;

  always #10 clk = ~clk; // 50 MHz

  sgdma_engine #(.MAX_ELEMS(4)) i_sgdma_engine (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .m_req_valid(m_req_valid), .m_req_ready(m_req_ready),
    .m_req_write(m_req_write), .m_req_addr(m_req_addr),
    .m_req_wdata(m_req_wdata), .m_rsp_valid(m_rsp_valid),
    .m_rsp_rdata(m_rsp_rdata), .m_rsp_err(m_rsp_err), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int req_count = 0;
  int ncyc = 0;
  string cur_tag = "R1";

  logic [31:0] mem [0:1023];
  logic [31:0] exp_addr [$];
  logic [31:0] exp_data [$];
  logic [31:0] err_rd_addr = 32'hFFFF_FFFF;
  logic [31:0] err_wr_addr = 32'hFFFF_FFFF;
  logic        rsp_due = 1'b0;
  logic        rsp_err_q = 1'b0;
  logic [31:0] rsp_data_q = '0;

  task automatic check32(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory model and scoreboard monitor, all on the falling edge
  always @(negedge clk) begin
    ncyc++;
    if (rsp_due) begin
      m_rsp_valid = 1'b1;
      m_rsp_rdata = rsp_data_q;
      m_rsp_err   = rsp_err_q;
      rsp_due     = 1'b0;
    end else begin
      m_rsp_valid = 1'b0;
      m_rsp_err   = 1'b0;
    end
    m_req_ready = !rst && ((ncyc % 5) != 2);
    if (m_req_valid && m_req_ready) begin
      req_count++;
      rsp_due = 1'b1;
      if (m_req_write) begin
        rsp_err_q = (m_req_addr == err_wr_addr);
        if (!rsp_err_q) mem[m_req_addr[11:2]] = m_req_wdata;
        if (exp_addr.size() == 0) begin
          n_cmp++; n_bad++;
          $display("FAIL %s: actual unexpected write %h@%h expected none", cur_tag, m_req_wdata, m_req_addr);
        end else begin
          check32(cur_tag, m_req_addr, exp_addr.pop_front());
          check32(cur_tag, m_req_wdata, exp_data.pop_front());
        end
      end else begin
        rsp_err_q  = (m_req_addr == err_rd_addr);
        rsp_data_q = mem[m_req_addr[11:2]];
      end
    end
  end

  task automatic reg_write(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic reg_read(input logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic fill_src();
    for (int i = 256; i < 1024; i++) mem[i] = (i * 32'h9E37_79B1) ^ 32'h5A5A_0000;
  endtask

  task automatic put_desc(input int idx, input logic [31:0] s, input logic [31:0] d, input logic [31:0] c);
    mem[idx*3]     = s;
    mem[idx*3 + 1] = d;
    mem[idx*3 + 2] = c;
  endtask

  // driver side of the scoreboard: expected writes of one element
  task automatic push_elem(input logic [31:0] s, input logic [31:0] d, input int nwords);
    for (int i = 0; i < nwords; i++) begin
      exp_addr.push_back(d + 32'(4*i));
      exp_data.push_back(mem[(s >> 2) + 32'(i)]);
    end
  endtask

  task automatic wait_irq(input string tag);
    int t = 0;
    while (!irq && t < 20000) begin @(negedge clk); t++; end
    n_cmp++;
    if (!irq) begin n_bad++; $display("FAIL %s: actual irq 0 expected 1", tag); end
  endtask

  task automatic check_status(input string tag, input logic [31:0] exp);
    logic [31:0] v;
    reg_read(4'h4, v);
    check32(tag, v, exp);
    check32("R11", {31'b0, irq}, {31'b0, exp != 0});
  endtask

  task automatic finish_run(input string tag, input logic [31:0] exp_stat);
    int rc;
    wait_irq(tag);
    repeat (4) @(negedge clk);
    check_status(tag, exp_stat);
    check32(tag, exp_addr.size(), 0);
    rc = req_count;
    repeat (30) @(negedge clk);
    check32(tag, req_count, rc);
    reg_write(4'h4, 32'h1F);
    check_status("R11", 32'h0);
    exp_addr.delete(); exp_data.delete();
    err_rd_addr = 32'hFFFF_FFFF; err_wr_addr = 32'hFFFF_FFFF;
  endtask

  task automatic start_run();
    reg_write(4'h8, 32'h0);
    reg_write(4'h0, 32'h1);
  endtask

  initial begin
    logic [31:0] v;
    fill_src();
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: reset state
    check_status("R1", 32'h0);
    check32("R1", req_count, 0);

    // R2: base register readback
    reg_write(4'h8, 32'h0000_1230);
    reg_read(4'h8, v);
    check32("R2", v, 32'h0000_1230);

    // R4 R5: single final element, 256 bytes
    cur_tag = "R4";
    put_desc(0, 32'h400, 32'hA00, 32'h8000_0100);
    push_elem(32'h400, 32'hA00, 64);
    start_run();
    finish_run("R5", 32'h03);

    // R11: clear one bit at a time
    cur_tag = "R11";
    put_desc(0, 32'h500, 32'hB00, 32'h8000_0100);
    push_elem(32'h500, 32'hB00, 64);
    start_run();
    wait_irq("R11");
    repeat (4) @(negedge clk);
    reg_write(4'h4, 32'h1);
    check_status("R11", 32'h02);
    reg_write(4'h4, 32'h0);
    check_status("R11", 32'h02);
    reg_write(4'h4, 32'h2);
    check_status("R11", 32'h00);

    // R2 R3 R5: three elements in order, reserved bits set in the middle one
    cur_tag = "R3";
    fill_src();
    put_desc(0, 32'h400, 32'hA00, 32'h0000_0200);
    put_desc(1, 32'h600, 32'hC00, 32'h7FFC_0100);
    put_desc(2, 32'h700, 32'hD00, 32'h8000_0300);
    push_elem(32'h400, 32'hA00, 128);
    push_elem(32'h600, 32'hC00, 64);
    push_elem(32'h700, 32'hD00, 192);
    start_run();
    finish_run("R2", 32'h03);

    // R6: second element has a count that is not a block multiple
    cur_tag = "R6";
    put_desc(0, 32'h400, 32'hA00, 32'h0000_0100);
    put_desc(1, 32'h500, 32'hB00, 32'h8000_0180);
    push_elem(32'h400, 32'hA00, 64);
    start_run();
    finish_run("R6", 32'h10);

    // R6: zero count
    put_desc(0, 32'h400, 32'hA00, 32'h8000_0000);
    start_run();
    finish_run("R6", 32'h10);

    // R7: error on an element fetch word
    cur_tag = "R7";
    put_desc(0, 32'h400, 32'hA00, 32'h8000_0100);
    err_rd_addr = 32'h4;
    start_run();
    finish_run("R7", 32'h04);

    // R7: error on a source read in the middle of an element
    put_desc(0, 32'h400, 32'hA00, 32'h8000_0100);
    push_elem(32'h400, 32'hA00, 10);
    err_rd_addr = 32'h428;
    start_run();
    finish_run("R7", 32'h04);

    // R8: error on a destination write
    cur_tag = "R8";
    put_desc(0, 32'h400, 32'hA00, 32'h8000_0100);
    push_elem(32'h400, 32'hA00, 6);
    err_wr_addr = 32'hA14;
    start_run();
    finish_run("R8", 32'h08);

    // R9: no final flag within MAX_ELEMS (4) elements
    cur_tag = "R9";
    for (int i = 0; i < 5; i++) begin
      put_desc(i, 32'h400 + 32'(i*256), 32'hA00 + 32'(i*256), 32'h0000_0100);
      if (i < 4) push_elem(32'h400 + 32'(i*256), 32'hA00 + 32'(i*256), 64);
    end
    start_run();
    finish_run("R9", 32'h10);

    // R10: start written during an active run
    cur_tag = "R10";
    fill_src();
    put_desc(0, 32'h400, 32'hA00, 32'h0000_0100);
    put_desc(1, 32'h500, 32'hB00, 32'h8000_0100);
    push_elem(32'h400, 32'hA00, 64);
    push_elem(32'h500, 32'hB00, 64);
    start_run();
    repeat (40) @(negedge clk);
    reg_write(4'h0, 32'h1);
    finish_run("R10", 32'h03);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule